// File: doc/BRIEF.md
# Saturating Coefficient Mixing Matrix

This block forms four output audio channels from six signed 16-bit input samples: four channels from a serial audio bus and two from PDM decimation paths. Each output is a weighted sum of all six inputs. The weights are signed 8-bit fractional coefficients. One 16×8 multiplier and one 20-bit saturating accumulator are shared over all 24 products, one product per clock. After the sum is formed, the block applies a fixed saturating gain of eight, a per-pair volume scale and an output routing stage that can exchange the first channel pair with the second.

A one-cycle `strobe` starts a pass, and the block then works through its sequence on its own.
- The state machine waits in `ST_IDLE`.
- On a strobe it takes `IDLE_TO_MAC`, which also snapshots the inputs.
- It stays in `ST_MAC` for 24 cycles, channel by channel, with sources in the order serial 1–4 then PDM 1–2.
- It takes `MAC_TO_POST` after the last product.
- In `ST_POST` it registers the scaled and routed results.
- It takes `POST_TO_FIN` into `ST_FIN`, where `done` is high.
- It returns through `FIN_TO_IDLE`.

Coefficients are written one byte at a time through a small write port into an internal register file.

Top module: `mixm_top`

## Requirements
- R1: After reset, every output is 0, `done` is low, both volumes are 0, all 24 mix weights are 0 and routing is straight. A pass run with no coefficient writes therefore yields 0 on every output.
- R2: The write address map is as follows. Address 0 holds the volume for mixed channels 0–1. Address 1 holds the volume for mixed channels 2–3. Address 2+6·m+s holds the weight of source s for mixed channel m, where s = 0..3 are the serial channels and s = 4, 5 are the PDM channels. Address 31 holds routing. Writes to addresses 26–30 change nothing.
- R3: Each product contributes floor(x·c/8), with x and c read as signed. The contributions are added in source order 0..5 into a 20-bit accumulator. At each step the accumulator clamps to [−524288, 524287], so a later term of opposite sign moves the sum back from the clamp.
- R4: The pre-volume value is min/max-clamp(acc·8 to 20 bits) shifted right arithmetically by 4. A weight of 16 on a single source therefore passes that source unchanged, and large sums pin at +32767 or −32768.
- R5: The mixed channel value is floor(p·v/128). Here p is the R4 value and v is bits 6:0 of the channel's volume byte, read unsigned. Bit 7 of a volume byte is ignored, and v = 0 mutes the pair.
- R6: If bit 7 of the routing byte is clear, output o carries mixed channel o. If it is set, output o carries mixed channel o XOR 2, so pairs 0–1 and 2–3 are exchanged. The other routing bits are ignored.
- R7: The edge that samples `strobe` in `ST_IDLE` counts as edge 1. On edge 26, all four outputs update and `done` rises. `done` stays high for exactly one cycle, and the outputs hold until the next pass.
- R8: A strobe that arrives while a pass is running, including the cycle in which `done` is high, is ignored: it starts no pass and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | Sample strobe; starts a pass when idle |
| src_flat | input | 96 | Six 16-bit signed sources; source s at bits 16s+15:16s |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 5 | Coefficient write address |
| coef_wdata | input | 8 | Coefficient write data |
| out_flat | output | 64 | Four 16-bit signed outputs; output o at bits 16o+15:16o |
| done | output | 1 | One-cycle pulse: outputs are fresh |

## Verification
Two functions can meet in the same cycle: the one-cycle completion pulse and the acceptance of a new sample strobe. They also meet when a strobe lands in the middle of the multiply-accumulate run. The bench provokes both cases. It raises a strobe a few cycles into a pass, and raises another in the exact cycle it sees `done` high. It then counts `done` pulses over the following 40 cycles and expects exactly one. It also compares all four outputs against values computed arithmetically from its own copy of the coefficients. Sweeps over pseudo-random weights, volumes and routing bytes, together with deliberate clamp sequences, cover the arithmetic.

// File: rtl/mixm_pkg.sv
package mixm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_POST,
        ST_FIN
    } mix_state_t;

    localparam int ADDR_VOL_A = 0;
    localparam int ADDR_VOL_B = 1;
    localparam int ADDR_MIX0  = 2;
    localparam int ADDR_ROUTE = 31;

endpackage

// File: rtl/mixm_coef_rf.sv
module mixm_coef_rf
    import mixm_pkg::*;
#(
    parameter int CW      = 8,
    parameter int ENTRIES = 24,
    parameter int ADDR_W  = 5,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CW-1:0]     rd_coef,
    output logic [CW-2:0]     vol_a,
    output logic [CW-2:0]     vol_b,
    output logic              swap
);

    localparam int GAP_LO = ADDR_MIX0 + ENTRIES;

    logic [CW-1:0] mix_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_mix
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mix_q[g] <= '0;
            end else if (we && addr == ADDR_W'(ADDR_MIX0 + g)) begin
                mix_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vol_a <= '0;
            vol_b <= '0;
            swap  <= 1'b0;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_VOL_A)) vol_a <= wdata[CW-2:0];
            if (addr == ADDR_W'(ADDR_VOL_B)) vol_b <= wdata[CW-2:0];
            if (addr == ADDR_W'(ADDR_ROUTE)) swap  <= wdata[CW-1];
        end
    end

    assign rd_coef = mix_q[rd_idx];

    AST_GAP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr >= ADDR_W'(GAP_LO) && addr < ADDR_W'(ADDR_ROUTE))
        |=> ($stable(vol_a) && $stable(vol_b) && $stable(swap))); // R2

endmodule

// File: rtl/mixm_mac.sv
module mixm_mac #(
    parameter int DW      = 16,
    parameter int CW      = 8,
    parameter int AW      = 20,
    parameter int TERM_SH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic [DW-1:0] x,
    input  logic [CW-1:0] c,
    output logic [AW-1:0] acc_next
);

    localparam int PW = DW + CW;
    localparam int SW = PW + 1;
    localparam logic [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_sh;
    logic signed [SW-1:0] term;
    logic signed [SW-1:0] base;
    logic signed [SW-1:0] sum;
    logic [AW-1:0]        acc_q;

    assign prod    = $signed(x) * $signed(c);
    assign prod_sh = prod >>> TERM_SH;
    assign term    = {prod_sh[PW-1], prod_sh};
    assign base    = first ? '0 : {{(SW-AW){acc_q[AW-1]}}, acc_q};
    assign sum     = base + term;

    always_comb begin
        if (!sum[SW-1] && (|sum[SW-2:AW-1])) begin
            acc_next = ACC_MAX;
        end else if (sum[SW-1] && !(&sum[SW-2:AW-1])) begin
            acc_next = ACC_MIN;
        end else begin
            acc_next = sum[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_next;
        end
    end

    AST_ACC_PINNED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first && acc_q == ACC_MAX && !term[SW-1]) |-> (acc_next == ACC_MAX)); // R3
    AST_ACC_PINNED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first && acc_q == ACC_MIN && term[SW-1]) |-> (acc_next == ACC_MIN)); // R3

endmodule

// File: rtl/mixm_post.sv
module mixm_post #(
    parameter int DW     = 16,
    parameter int CW     = 8,
    parameter int AW     = 20,
    parameter int OUT_N  = 4,
    parameter int PRE_SH = 3
) (
    input  logic [OUT_N*AW-1:0] chan_acc,
    input  logic [CW-2:0]       vol_a,
    input  logic [CW-2:0]       vol_b,
    input  logic                swap,
    output logic [OUT_N*DW-1:0] y_flat
);

    localparam int HALF = OUT_N / 2;
    localparam int XW   = AW + PRE_SH;

    logic [DW-1:0] ch_y [OUT_N];

    for (genvar m = 0; m < OUT_N; m++) begin : g_chan
        logic [AW-1:0]          a;
        logic [XW-1:0]          sh;
        logic signed [AW-1:0]   clamp;
        logic signed [DW-1:0]   pre;
        logic [CW-2:0]          v;
        logic signed [DW+CW-1:0] sc;

        assign a  = chan_acc[m*AW +: AW];
        assign sh = {a, {PRE_SH{1'b0}}};

        always_comb begin
            if (!sh[XW-1] && (|sh[XW-2:AW-1])) begin
                clamp = {1'b0, {(AW-1){1'b1}}};
            end else if (sh[XW-1] && !(&sh[XW-2:AW-1])) begin
                clamp = {1'b1, {(AW-1){1'b0}}};
            end else begin
                clamp = sh[AW-1:0];
            end
        end

        assign pre = DW'(clamp >>> (AW - DW));

        if (m < HALF) begin : g_va
            assign v = vol_a;
        end else begin : g_vb
            assign v = vol_b;
        end

        assign sc      = pre * $signed({1'b0, v});
        assign ch_y[m] = DW'(sc >>> (CW - 1));
    end

    for (genvar o = 0; o < OUT_N; o++) begin : g_route
        assign y_flat[o*DW +: DW] = swap ? ch_y[(o + HALF) % OUT_N] : ch_y[o];
    end

endmodule

// File: rtl/mixm_top.sv
module mixm_top
    import mixm_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CW      = 8,
    parameter int AW      = 20,
    parameter int SRC_N   = 6,
    parameter int OUT_N   = 4,
    parameter int ADDR_W  = 5,
    parameter int TERM_SH = 3,
    parameter int PRE_SH  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [SRC_N*DW-1:0] src_flat,
    input  logic                coef_we,
    input  logic [ADDR_W-1:0]   coef_addr,
    input  logic [CW-1:0]       coef_wdata,
    output logic [OUT_N*DW-1:0] out_flat,
    output logic                done
);

    localparam int SRC_W = $clog2(SRC_N);
    localparam int CH_W  = $clog2(OUT_N);
    localparam int IDX_W = $clog2(SRC_N * OUT_N);

    mix_state_t state_q, state_d;

    logic [SRC_W-1:0]     src_q;
    logic [CH_W-1:0]      ch_q;
    logic [DW-1:0]        snap_q [SRC_N];
    logic [AW-1:0]        chan_res_q [OUT_N];
    logic [OUT_N*AW-1:0]  chan_flat;
    logic [OUT_N*DW-1:0]  y_flat;
    logic [OUT_N*DW-1:0]  out_q;
    logic [IDX_W-1:0]     idx;
    logic [CW-1:0]        coef;
    logic [CW-2:0]        vol_a, vol_b;
    logic                 swap;
    logic [AW-1:0]        acc_next;
    logic                 src_last, last_term, mac_en;

    assign src_last  = (src_q == SRC_W'(SRC_N - 1));
    assign last_term = src_last && (ch_q == CH_W'(OUT_N - 1));
    assign mac_en    = (state_q == ST_MAC);
    assign idx       = IDX_W'(ch_q) * IDX_W'(SRC_N) + IDX_W'(src_q);

    mixm_coef_rf #(
        .CW(CW), .ENTRIES(SRC_N * OUT_N), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
        .wdata(coef_wdata), .rd_idx(idx), .rd_coef(coef),
        .vol_a(vol_a), .vol_b(vol_b), .swap(swap)
    );

    mixm_mac #(
        .DW(DW), .CW(CW), .AW(AW), .TERM_SH(TERM_SH)
    ) u_mac (
        .clk(clk), .rst_n(rst_n), .en(mac_en), .first(src_q == '0),
        .x(snap_q[src_q]), .c(coef), .acc_next(acc_next)
    );

    for (genvar m = 0; m < OUT_N; m++) begin : g_flat
        assign chan_flat[m*AW +: AW] = chan_res_q[m];
    end

    mixm_post #(
        .DW(DW), .CW(CW), .AW(AW), .OUT_N(OUT_N), .PRE_SH(PRE_SH)
    ) u_post (
        .chan_acc(chan_flat), .vol_a(vol_a), .vol_b(vol_b),
        .swap(swap), .y_flat(y_flat)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (strobe)    state_d = ST_MAC;   // IDLE_TO_MAC
            ST_MAC:  if (last_term) state_d = ST_POST;  // MAC_TO_POST
            ST_POST:                state_d = ST_FIN;   // POST_TO_FIN
            ST_FIN:                 state_d = ST_IDLE;  // FIN_TO_IDLE
        endcase
    end

    // Datapath sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            ch_q  <= '0;
            out_q <= '0;
            for (int i = 0; i < SRC_N; i++) snap_q[i] <= '0;
            for (int m = 0; m < OUT_N; m++) chan_res_q[m] <= '0;
        end else begin
            if (state_q == ST_IDLE && strobe) begin
                src_q <= '0;
                ch_q  <= '0;
                for (int i = 0; i < SRC_N; i++) snap_q[i] <= src_flat[i*DW +: DW];
            end
            if (state_q == ST_MAC) begin
                if (src_last) begin
                    src_q            <= '0;
                    ch_q             <= ch_q + 1'b1;
                    chan_res_q[ch_q] <= acc_next;
                end else begin
                    src_q <= src_q + 1'b1;
                end
            end
            if (state_q == ST_POST) begin
                out_q <= y_flat;
            end
        end
    end

    // Outputs
    always_comb begin
        out_flat = out_q;
        done     = (state_q == ST_FIN);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_POST) |=> $stable(out_flat)); // R7
    AST_BUSY_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN && strobe) |=> (state_q == ST_IDLE && !done)); // R8
    AST_MUTE_PAIR_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST && vol_a == '0 && !swap) |=> (out_flat[2*DW-1:0] == '0)); // R5
    AST_MAC_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && strobe) |=> (state_q == ST_MAC && src_q == '0 && ch_q == '0)); // R7

endmodule

// File: tb/sim_mixm_top.sv
module sim_mixm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [95:0] src_flat = '0;
    logic        coef_we = 1'b0;
    logic [4:0]  coef_addr = '0;
    logic [7:0]  coef_wdata = '0;
    logic [63:0] out_flat;
    logic        done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int done_cnt = 0;
    int kb [32];
    int xs [6];
    bit [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    mixm_top u0 (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .src_flat(src_flat),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .out_flat(out_flat), .done(done)
    );

    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R7 watchdog actual=%0d cycles expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'(rng & 32'h7fff_ffff);
    endfunction

    function automatic int s8(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic int chan_val(int m);
        int acc = 0;
        int sh, pre, v;
        for (int s = 0; s < 6; s++) begin
            acc = acc + ((xs[s] * s8(kb[2 + m*6 + s])) >>> 3);
            if (acc > 524287) acc = 524287;
            if (acc < -524288) acc = -524288;
        end
        sh = acc * 8;
        if (sh > 524287) sh = 524287;
        if (sh < -524288) sh = -524288;
        pre = sh >>> 4;
        v = ((m < 2) ? kb[0] : kb[1]) & 127;
        return (pre * v) >>> 7;
    endfunction

    function automatic int exp_out(int o);
        return ((kb[31] & 128) != 0) ? chan_val(o ^ 2) : chan_val(o);
    endfunction

    function automatic int got_out(int o);
        logic [15:0] w;
        w = out_flat[o*16 +: 16];
        return int'($signed(w));
    endfunction

    task automatic chk(string tag, int got, int expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, expv);
        end
    endtask

    task automatic wr(int a, int v);
        @(negedge clk);
        coef_we = 1'b1;
        coef_addr = a[4:0];
        coef_wdata = v[7:0];
        @(negedge clk);
        coef_we = 1'b0;
        if (a <= 25 || a == 31) kb[a] = v & 255;
    endtask

    task automatic set_in();
        for (int s = 0; s < 6; s++) src_flat[s*16 +: 16] = xs[s][15:0];
    endtask

    task automatic run(output int lat);
        @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        for (int o = 0; o < 4; o++) chk(tag, got_out(o), exp_out(o));
    endtask

    task automatic diag(int w);
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 6; s++)
                wr(2 + m*6 + s, (s == m) ? w : 0);
    endtask

    initial begin
        int lat;
        int d0;
        for (int a = 0; a < 32; a++) kb[a] = 0;
        kb[31] = 127;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out reset", int'(out_flat != 0), 0);
        chk("R1 done reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        xs = '{12000, -9000, 30000, -32768, 5000, 777};
        set_in();
        run(lat);
        check_all("R1 zero coefs after reset");
        chk("R7 latency", lat, 26);

        // R1/R5: diagonal weights but volumes still at reset zero
        diag(16);
        run(lat);
        check_all("R1 volume reset mutes");

        // R4: weight 16 unity, volume 127
        wr(0, 127);
        wr(1, 127);
        run(lat);
        check_all("R4 unity weight");
        for (int i = 0; i < 4; i++) chk("R4 unity exact", got_out(i), (xs[i] * 127) >>> 7);

        // R3: positive and negative clamp
        for (int a = 2; a < 26; a++) wr(a, 127);
        xs = '{32767, 32767, 32767, 32767, 32767, 32767};
        set_in();
        run(lat);
        check_all("R3 positive clamp");
        chk("R4 pinned high", got_out(0), 32511);
        for (int a = 2; a < 26; a++) wr(a, 128);
        run(lat);
        check_all("R3 negative clamp");
        chk("R4 pinned low", got_out(0), -32512);
        // R3: order-dependent clamp, late negative terms pull back
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) wr(2 + m*6 + s, 127);
            wr(2 + m*6 + 4, 128);
            wr(2 + m*6 + 5, 128 + m * 20);
        end
        run(lat);
        check_all("R3 clamp then recover");

        // R5: volume sweep including bit 7 set
        diag(16);
        xs = '{20000, -20000, 31000, -31000, 0, 0};
        set_in();
        for (int v = 0; v < 256; v += 17) begin
            wr(0, v);
            wr(1, 255 - v);
            run(lat);
            check_all("R5 volume sweep");
        end

        // R6: routing byte values
        wr(0, 100);
        wr(1, 60);
        wr(31, 128); run(lat); check_all("R6 swap 0x80");
        wr(31, 197); run(lat); check_all("R6 swap 0xC5");
        wr(31, 0);   run(lat); check_all("R6 straight 0x00");
        wr(31, 85);  run(lat); check_all("R6 straight 0x55");
        wr(31, 128); run(lat);
        chk("R6 out0 takes chan2", got_out(0), chan_val(2));

        // R2: gap addresses have no effect
        for (int a = 26; a < 31; a++) wr(a, 255);
        run(lat);
        check_all("R2 gap writes ignored");
        chk("R2 route kept", got_out(2), chan_val(0));

        // R3: pseudo-random sweep
        for (int p = 0; p < 40; p++) begin
            for (int a = 2; a < 26; a++) wr(a, (p < 20) ? ((nxt() % 64) + ((nxt() & 1) ? 192 : 0)) : (nxt() & 255));
            wr(0, nxt() & 255);
            wr(1, nxt() & 255);
            wr(31, nxt() & 255);
            for (int s = 0; s < 6; s++) xs[s] = (nxt() & 65535) - 32768;
            set_in();
            run(lat);
            check_all("R3 random sweep");
            chk("R7 latency sweep", lat, 26);
        end

        // R8: strobe mid-pass and in the done cycle
        @(negedge clk);
        d0 = done_cnt;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        repeat (4) @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        repeat (40) @(negedge clk);
        chk("R8 single done", done_cnt - d0, 1);
        check_all("R8 result intact");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule